// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital control core of a successive-approximation converter with a 14-bit result. A rising edge on the convert-start input puts the track/hold into hold, raises the busy/end-of-conversion pin and starts a conversion. The conversion runs for a fixed sixteen conversion-clock cycles. The clock that paces it is chosen once per conversion, from the level of the external clock pin at the start edge. During the conversion the sequencer drives a trial code to the DAC and reads the comparator, deciding one bit per cycle from the most significant bit down. At the end it latches the result, returns the track/hold to track and ends the busy indication.

The latched result is offered on a three-state parallel bus. The bus is enabled only while chip-select and read are both low. The comparator, the DAC and the internal oscillator lie outside the block: they appear as a comparator input, a trial-code output and an oscillator input. All inputs are sampled in the system clock domain, and a conversion clock edge is a rising edge of the selected source seen there.

Top module: `sar_seq`

## Requirements
- R1: When convert-start rises while the sequencer is idle and standby is not asserted, `hold` and `busy_eoc` are both high from the next system clock onward.
- R2: When `clkin` is high at the start edge, only rising edges of `clkin` advance the conversion. When it is low, only rising edges of `osc_tick` advance it.
- R3: A conversion ends on exactly the sixteenth rising edge of the selected conversion clock after the start. `hold` is still high after the fifteenth edge.
- R4: Conversion-clock edge 1 loads the trial code with only bit 13 set. Edges 2 to 15 each decide one bit, from bit 13 down to bit 0. On each of these edges the bit under trial is kept when `comp_in` is 1 and cleared when it is 0, and the next lower bit is set as the new trial. Edge 16 latches the code as the result. With `comp_in` = (input code >= `dac_code`), the result equals the input code.
- R5: If convert-start is low at the end of conversion, `busy_eoc` and `hold` both fall in the cycle after the final edge, and `busy_eoc` stays low.
- R6: If convert-start is high at the end of conversion, `busy_eoc` is low for one system clock, then high for exactly one system clock, then low.
- R7: `db_oe` is 1 and `db` carries the latched result, bit 13 as MSB, only while `cs_n` and `rd_n` are both 0. Otherwise `db_oe` is 0 and `db` is released to high impedance.
- R8: A convert-start rising edge while a conversion is in progress is ignored. The conversion keeps its count and its result.
- R9: While `stby_n` is 0, the sequencer is idle from the next clock: `hold` is 0 and `busy_eoc` is 0. The latched result is unchanged, and convert-start edges are ignored.
- R10: After reset, `hold` and `busy_eoc` are 0 and the latched result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_n | input | 1 | Active-low standby |
| convst | input | 1 | Convert start, rising edge starts a conversion |
| clkin | input | 1 | External conversion clock and source select level |
| osc_tick | input | 1 | Internal oscillator output |
| comp_in | input | 1 | Comparator, 1 when the input is at or above the trial code |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read |
| dac_code | output | 14 | Trial code to the DAC |
| hold | output | 1 | Track/hold control, 1 = hold |
| busy_eoc | output | 1 | Busy or end-of-conversion indication |
| db_oe | output | 1 | Bus drive enable |
| db | output | 14 | Three-state result bus |

## Verification
Some rules are checked by assertions on every cycle: start raises hold and busy, a start edge during a conversion leaves the count and trial code untouched, and standby idles the sequencer without changing the result. They also check that the bus carries the result whenever it is enabled and that the end-of-conversion pulse lasts one cycle. Other behaviour is shown only by the bench scenarios. These cover the exact sixteen-edge length, the choice of clock source, the binary search converging on codes at both ends and in the middle of the range, and the two pin behaviours at the end of conversion.

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stby_n,
  input  logic         convst,
  input  logic         clkin,
  input  logic         osc_tick,
  input  logic         comp_in,
  input  logic         cs_n,
  input  logic         rd_n,
  output logic [W-1:0] dac_code,
  output logic         hold,
  output logic         busy_eoc,
  output logic         db_oe,
  output logic [W-1:0] db
);
  localparam int NCYC = W + 2;
  localparam int CW = $clog2(NCYC + 1);

  logic conv_q, ext_q, osc_q, sel_ext, active, pulse_pend;
  logic [CW-1:0] cnt;
  logic [W-1:0] sar, res_q;

  wire start = convst & ~conv_q & ~active & stby_n;
  wire tick  = active & (sel_ext ? (clkin & ~ext_q) : (osc_tick & ~osc_q));
  wire last  = tick && (cnt == CW'(NCYC - 1));
  wire [CW-1:0] sh = CW'(W) - cnt;
  wire [W-1:0] cur_m = {{(W-1){1'b0}}, 1'b1} << sh;
  wire [W-1:0] nxt_m = cur_m >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_q <= 1'b0; ext_q <= 1'b0; osc_q <= 1'b0;
      sel_ext <= 1'b0; active <= 1'b0; pulse_pend <= 1'b0;
      hold <= 1'b0; busy_eoc <= 1'b0;
      cnt <= '0; sar <= '0; res_q <= '0;
    end else begin
      conv_q <= convst;
      ext_q  <= clkin;
      osc_q  <= osc_tick;
      if (!stby_n) begin
        active <= 1'b0; hold <= 1'b0; busy_eoc <= 1'b0; pulse_pend <= 1'b0;
      end else if (start) begin
        active <= 1'b1; hold <= 1'b1; busy_eoc <= 1'b1;
        sel_ext <= clkin; cnt <= '0; sar <= '0; pulse_pend <= 1'b0;
      end else begin
        if (pulse_pend) begin
          busy_eoc <= 1'b1; pulse_pend <= 1'b0;
        end else if (!active) begin
          busy_eoc <= 1'b0;
        end
        if (tick) begin
          cnt <= cnt + 1'b1;
          if (cnt == '0) begin
            sar <= {1'b1, {(W-1){1'b0}}};
          end else if (!last) begin
            sar <= (comp_in ? sar : (sar & ~cur_m)) | nxt_m;
          end else begin
            res_q <= sar; active <= 1'b0; hold <= 1'b0;
            busy_eoc <= 1'b0; pulse_pend <= convst;
          end
        end
      end
    end
  end

  assign dac_code = sar;
  assign db_oe = ~cs_n & ~rd_n;
  assign db = db_oe ? res_q : {W{1'bz}};

  // R1
  start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_n && $rose(convst) && !hold) |=> (hold && busy_eoc));
  // R5
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hold) && stby_n && !conv_q) |-> !busy_eoc);
  // R6
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_eoc && !hold && stby_n && !$rose(convst)) |=> (!busy_eoc || hold));
  // R7
  bus_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rd_n) |-> (db == res_q));
  // R8
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $rose(convst) && stby_n && !tick) |=> ($stable(cnt) && $stable(sar)));
  // R9
  standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_n |=> (!hold && !busy_eoc && $stable(res_q)));
endmodule

// File: tb/sar_seq_tb.sv
`timescale 1ns/1ps
module sar_seq_tb;
  localparam int W = 14;
  logic clk = 1'b0, rst_n = 1'b0, stby_n = 1'b1, convst = 1'b0, clkin = 1'b0;
  logic osc_tick = 1'b0, cs_n = 1'b0, rd_n = 1'b0;
  logic [W-1:0] vin = '0, last_res = '0;
  logic [W-1:0] dac_code, db;
  logic hold, busy_eoc, db_oe, comp_in;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct { logic [W-1:0] v; bit eoc; } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;
  assign comp_in = (vin >= dac_code);

  sar_seq #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .convst(convst), .clkin(clkin),
    .osc_tick(osc_tick), .comp_in(comp_in), .cs_n(cs_n), .rd_n(rd_n),
    .dac_code(dac_code), .hold(hold), .busy_eoc(busy_eoc), .db_oe(db_oe), .db(db));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      repeat (2) @(negedge clk);
      osc_tick = ~osc_tick;
    end
  end

  initial begin : monitor
    logic prev_hold;
    exp_t e;
    prev_hold = 1'b0;
    forever begin
      @(negedge clk);
      if (prev_hold && !hold && stby_n) begin
        e = sb.pop_front();
        check(db == e.v, "R4 result", int'(db), int'(e.v));
        check(busy_eoc == 1'b0, "R5 busy low at end", int'(busy_eoc), 0);
        @(negedge clk);
        check(busy_eoc == e.eoc, "R6 pin after end", int'(busy_eoc), int'(e.eoc));
        @(negedge clk);
        check(busy_eoc == 1'b0, "R6 pin settles low", int'(busy_eoc), 0);
      end
      prev_hold = hold;
    end
  end

  task automatic wait_end();
    for (int i = 0; i < 400 && hold; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic conv_int(input logic [W-1:0] v, input bit eoc);
    exp_t e;
    @(negedge clk);
    vin = v; clkin = 1'b0; convst = 1'b1;
    e.v = v; e.eoc = eoc; sb.push_back(e);
    @(negedge clk);
    check(hold && busy_eoc, "R1 start", int'({hold, busy_eoc}), 3);
    if (!eoc) begin
      repeat (3) @(negedge clk);
      convst = 1'b0;
    end
    wait_end();
    convst = 1'b0;
    repeat (2) @(negedge clk);
    last_res = v;
  endtask

  task automatic conv_ext(input logic [W-1:0] v);
    exp_t e;
    @(negedge clk);
    vin = v; clkin = 1'b1; convst = 1'b1;
    e.v = v; e.eoc = 1'b0; sb.push_back(e);
    @(negedge clk);
    clkin = 1'b0;
    repeat (80) @(negedge clk);
    check(hold == 1'b1, "R2 oscillator ignored in external mode", int'(hold), 1);
    for (int i = 1; i <= 16; i++) begin
      clkin = 1'b1;
      if (i == 5) convst = 1'b0;
      if (i == 6) convst = 1'b1;
      if (i == 8) convst = 1'b0;
      @(negedge clk);
      if (i == 15) check(hold == 1'b1, "R3 still holding after 15 edges", int'(hold), 1);
      if (i == 16) check(hold == 1'b0, "R3 ends on 16th edge", int'(hold), 0);
      @(negedge clk);
      clkin = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    last_res = v;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(hold == 1'b0 && busy_eoc == 1'b0, "R10 reset outputs", int'({hold, busy_eoc}), 0);
    check(db == '0, "R10 reset result", int'(db), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    conv_int(14'h2AAA, 1'b0);
    conv_int(14'h3FFF, 1'b0);
    conv_int(14'h0000, 1'b1);
    conv_int(14'h1555, 1'b1);
    conv_ext(14'h2000);
    conv_ext(14'h1FFF);

    cs_n = 1'b1; rd_n = 1'b0; @(negedge clk);
    check(db_oe == 1'b0, "R7 cs high disables bus", int'(db_oe), 0);
    cs_n = 1'b0; rd_n = 1'b1; @(negedge clk);
    check(db_oe == 1'b0, "R7 rd high disables bus", int'(db_oe), 0);
    rd_n = 1'b0; @(negedge clk);
    check(db_oe == 1'b1 && db == last_res, "R7 bus drives result", int'(db), int'(last_res));

    @(negedge clk);
    vin = 14'h0F0F; clkin = 1'b0; convst = 1'b1;
    repeat (20) @(negedge clk);
    stby_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(hold == 1'b0 && busy_eoc == 1'b0, "R9 standby idles", int'({hold, busy_eoc}), 0);
    check(db == last_res, "R9 result kept", int'(db), int'(last_res));
    convst = 1'b0; @(negedge clk); convst = 1'b1;
    repeat (10) @(negedge clk);
    check(hold == 1'b0, "R9 start ignored in standby", int'(hold), 0);
    stby_n = 1'b1; convst = 1'b0;
    repeat (4) @(negedge clk);
    check(hold == 1'b0 && db == last_res, "R9 idle after standby", int'(db), int'(last_res));

    conv_int(14'h0F0F, 1'b0);
    check(sb.size() == 0, "R4 scoreboard drained", sb.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule